// File: doc/BRIEF.md
# Exception priority and entry sequencer

This block sits next to the pipeline of a small 32-bit core. Each cycle it samples the exception request lines, chooses one winner by a fixed priority, and in the next cycle presents the entry frame for that winner. The frame holds the link value for the banked link register, the saved status word for the banked SPSR, the new status word and the vector fetch address. When a data abort and an unmasked FIQ arrive together, the abort frame comes first. The FIQ frame follows in the next cycle and is built from the abort handler's own state. A normal return from the FIQ handler therefore lands on the first instruction of the abort handler.

The same output registers also carry the return path. The core supplies the banked link register, the saved status word and the kind of exception being left. The block presents the restored PC, which is the link value minus an offset for that kind, and the restored status word. Register storage, decode and memory are outside the block.

Status word layout: bits [4:0] mode, bit 5 compact 16-bit instruction state (T), bit 6 FIQ disable (F), bit 7 IRQ disable (I), all other bits passed through.

Top module: `exc_seq`

## Requirements
- R1: Winner order is reset, pending chained FIQ, data abort, FIQ, IRQ, prefetch abort, then breakpoint, undefined or software interrupt (mutually exclusive). FIQ counts only when status bit 6 is 0, and IRQ only when status bit 7 is 0. The entry appears one cycle after sampling with `ent_valid_o`=1 and `kind_o` coded reset 0, undefined 1, SWI 2, prefetch abort 3, data abort 4, breakpoint 5, IRQ 6, FIQ 7.
- R2: A data abort sampled together with an unmasked FIQ gives the abort entry and then, one cycle later, a FIQ entry. That FIQ entry uses PC = abort vector and status = the abort entry's new status. Requests other than reset in that second cycle are dropped. A masked FIQ gives no second entry.
- R3: Returning from such a FIQ with the link value it produced restores PC to the abort vector, 0x10.
- R4: In 32-bit state (bit 5 = 0) the link value is PC+4 for undefined, SWI, prefetch abort, breakpoint, IRQ and FIQ, and PC+8 for data abort. A reset entry writes link 0.
- R5: In 16-bit state (bit 5 = 1) the link value is PC+2 for undefined and SWI, PC+4 for prefetch abort, breakpoint, IRQ and FIQ, and PC+8 for data abort.
- R6: On entry `spsr_o` equals the status word the entry was taken from.
- R7: The new mode bits are 10011 for reset and SWI, 11011 for undefined, 10111 for both aborts and breakpoint, 10010 for IRQ, and 10001 for FIQ.
- R8: Every entry clears bit 5 and sets bit 7. Reset and FIQ entries also set bit 6. All other status bits are copied.
- R9: Vector addresses are reset 0x00, undefined 0x04, SWI 0x08, prefetch abort and breakpoint 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R10: A return request with no exception request gives `ret_valid_o`=1, `pc_o` = link minus 0 (reset, undefined, SWI), 4 (prefetch abort, breakpoint, IRQ, FIQ) or 8 (data abort), and `cpsr_o` = the saved status. If an exception request is present in the same cycle, the return is dropped.
- R11: After reset both valid outputs are 0 and all data outputs are 0. Data outputs hold their value in cycles with no entry and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset exception request |
| dabt_i | input | 1 | Data abort request |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Interrupt request |
| pabt_i | input | 1 | Prefetch abort reaching execute |
| und_i | input | 1 | Undefined instruction request |
| swi_i | input | 1 | Software interrupt request |
| bkpt_i | input | 1 | Breakpoint reaching execute |
| pc_i | input | DW | Address of the current instruction |
| cpsr_i | input | DW | Current status word |
| ret_i | input | 1 | Exception return request |
| ret_kind_i | input | 3 | Kind being returned from (R1 code) |
| ret_lr_i | input | DW | Banked link register |
| ret_spsr_i | input | DW | Banked saved status |
| ent_valid_o | output | 1 | Entry frame valid |
| ret_valid_o | output | 1 | Return frame valid |
| kind_o | output | 3 | Kind entered or left |
| lr_o | output | DW | Link register write value |
| spsr_o | output | DW | Saved status write value |
| cpsr_o | output | DW | New or restored status word |
| pc_o | output | DW | Vector or restored PC |

## Verification
The only hidden state is the pending chained FIQ flag. If it is set wrongly, an extra FIQ entry appears one cycle after an unrelated abort. If it is lost, the FIQ that was taken together with an abort never appears, and the second cycle after the request shows no entry. A wrong chain source shows in that same cycle as a link value other than 0x14 or a saved status that does not equal the abort entry's status. Every other error shows on the frame one cycle after the request, because the frame is computed from that cycle's inputs alone.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_UND  = 3'd1,
    EXC_SWI  = 3'd2,
    EXC_PABT = 3'd3,
    EXC_DABT = 3'd4,
    EXC_BKPT = 3'd5,
    EXC_IRQ  = 3'd6,
    EXC_FIQ  = 3'd7
  } exc_e;

  localparam int MODE_W = 5;
  localparam int T_BIT  = 5;
  localparam int F_BIT  = 6;
  localparam int I_BIT  = 7;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  localparam logic [5:0] DABT_VEC = 6'h10;

  function automatic logic [MODE_W-1:0] mode_of(exc_e k);
    case (k)
      EXC_RST, EXC_SWI:            mode_of = MODE_SVC;
      EXC_UND:                     mode_of = MODE_UND;
      EXC_PABT, EXC_DABT, EXC_BKPT: mode_of = MODE_ABT;
      EXC_IRQ:                     mode_of = MODE_IRQ;
      default:                     mode_of = MODE_FIQ;
    endcase
  endfunction

  function automatic logic [5:0] vec_off(exc_e k);
    case (k)
      EXC_RST:            vec_off = 6'h00;
      EXC_UND:            vec_off = 6'h04;
      EXC_SWI:            vec_off = 6'h08;
      EXC_PABT, EXC_BKPT: vec_off = 6'h0C;
      EXC_DABT:           vec_off = DABT_VEC;
      EXC_IRQ:            vec_off = 6'h18;
      default:            vec_off = 6'h1C;
    endcase
  endfunction

  // link offset over the current instruction address
  function automatic logic [3:0] link_add(exc_e k, logic thumb);
    case (k)
      EXC_UND, EXC_SWI: link_add = thumb ? 4'd2 : 4'd4;
      EXC_DABT:         link_add = 4'd8;
      EXC_RST:          link_add = 4'd0;
      default:          link_add = 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] ret_sub(exc_e k);
    case (k)
      EXC_RST, EXC_UND, EXC_SWI: ret_sub = 4'd0;
      EXC_DABT:                  ret_sub = 4'd8;
      default:                   ret_sub = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic rst_req_i,
  input  logic chain_i,
  input  logic dabt_i,
  input  logic fiq_i,
  input  logic irq_i,
  input  logic pabt_i,
  input  logic bkpt_i,
  input  logic und_i,
  input  logic swi_i,
  input  logic f_mask_i,
  input  logic i_mask_i,
  output logic hit_o,
  output exc_e kind_o,
  output logic from_chain_o,
  output logic chain_set_o
);
  localparam int NREQ = 9;

  function automatic exc_e slot_kind(int i);
    case (i)
      0:       slot_kind = EXC_RST;
      1:       slot_kind = EXC_FIQ;
      2:       slot_kind = EXC_DABT;
      3:       slot_kind = EXC_FIQ;
      4:       slot_kind = EXC_IRQ;
      5:       slot_kind = EXC_PABT;
      6:       slot_kind = EXC_BKPT;
      7:       slot_kind = EXC_UND;
      default: slot_kind = EXC_SWI;
    endcase
  endfunction

  logic            fiq_ok;
  logic [NREQ-1:0] req;

  assign fiq_ok = fiq_i & ~f_mask_i;
  assign req = {swi_i, und_i, bkpt_i, pabt_i, irq_i & ~i_mask_i,
                fiq_ok, dabt_i, chain_i, rst_req_i};

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    kind_o = EXC_RST;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit_o  = 1'b1;
        kind_o = slot_kind(i);
      end
    end
  end

  assign from_chain_o = chain_i & ~rst_req_i;
  assign chain_set_o  = hit_o & (kind_o == EXC_DABT) & fiq_ok;
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int              DW       = 32,
  parameter logic [DW-1:0]   VEC_BASE = '0
) (
  input  exc_e          kind_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] cpsr_i,
  output logic [DW-1:0] lr_o,
  output logic [DW-1:0] spsr_o,
  output logic [DW-1:0] cpsr_o,
  output logic [DW-1:0] vec_o
);
  always_comb begin
    lr_o   = (kind_i == EXC_RST) ? '0 : pc_i + DW'(link_add(kind_i, cpsr_i[T_BIT]));
    spsr_o = cpsr_i;
    cpsr_o = cpsr_i;
    cpsr_o[MODE_W-1:0] = mode_of(kind_i);
    cpsr_o[T_BIT] = 1'b0;
    cpsr_o[I_BIT] = 1'b1;
    if (kind_i == EXC_FIQ || kind_i == EXC_RST) cpsr_o[F_BIT] = 1'b1;
    vec_o  = VEC_BASE + DW'(vec_off(kind_i));
  end
endmodule

// File: rtl/exc_ret.sv
module exc_ret
  import exc_pkg::*;
#(
  parameter int DW = 32
) (
  input  exc_e          kind_i,
  input  logic [DW-1:0] lr_i,
  input  logic [DW-1:0] spsr_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] cpsr_o
);
  assign pc_o   = lr_i - DW'(ret_sub(kind_i));
  assign cpsr_o = spsr_i;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rst_req_i,
  input  logic          dabt_i,
  input  logic          fiq_i,
  input  logic          irq_i,
  input  logic          pabt_i,
  input  logic          und_i,
  input  logic          swi_i,
  input  logic          bkpt_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] cpsr_i,
  input  logic          ret_i,
  input  logic [2:0]    ret_kind_i,
  input  logic [DW-1:0] ret_lr_i,
  input  logic [DW-1:0] ret_spsr_i,
  output logic          ent_valid_o,
  output logic          ret_valid_o,
  output logic [2:0]    kind_o,
  output logic [DW-1:0] lr_o,
  output logic [DW-1:0] spsr_o,
  output logic [DW-1:0] cpsr_o,
  output logic [DW-1:0] pc_o
);
  localparam logic [DW-1:0] CHAIN_PC = VEC_BASE + DW'(DABT_VEC);

  logic          chain_q;
  logic          hit, from_chain, chain_set;
  exc_e          win;
  logic [DW-1:0] src_pc, src_cpsr;
  logic [DW-1:0] e_lr, e_spsr, e_cpsr, e_vec;
  logic [DW-1:0] r_pc, r_cpsr;

  exc_arb u_arb (
    .rst_req_i   (rst_req_i),
    .chain_i     (chain_q),
    .dabt_i      (dabt_i),
    .fiq_i       (fiq_i),
    .irq_i       (irq_i),
    .pabt_i      (pabt_i),
    .bkpt_i      (bkpt_i),
    .und_i       (und_i),
    .swi_i       (swi_i),
    .f_mask_i    (cpsr_i[F_BIT]),
    .i_mask_i    (cpsr_i[I_BIT]),
    .hit_o       (hit),
    .kind_o      (win),
    .from_chain_o(from_chain),
    .chain_set_o (chain_set)
  );

  // chained FIQ is built from the abort handler's state
  assign src_pc   = from_chain ? CHAIN_PC : pc_i;
  assign src_cpsr = from_chain ? cpsr_o   : cpsr_i;

  exc_entry #(.DW(DW), .VEC_BASE(VEC_BASE)) u_entry (
    .kind_i(win),
    .pc_i  (src_pc),
    .cpsr_i(src_cpsr),
    .lr_o  (e_lr),
    .spsr_o(e_spsr),
    .cpsr_o(e_cpsr),
    .vec_o (e_vec)
  );

  exc_ret #(.DW(DW)) u_ret (
    .kind_i(exc_e'(ret_kind_i)),
    .lr_i  (ret_lr_i),
    .spsr_i(ret_spsr_i),
    .pc_o  (r_pc),
    .cpsr_o(r_cpsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q     <= 1'b0;
      ent_valid_o <= 1'b0;
      ret_valid_o <= 1'b0;
      kind_o      <= '0;
      lr_o        <= '0;
      spsr_o      <= '0;
      cpsr_o      <= '0;
      pc_o        <= '0;
    end else begin
      chain_q     <= chain_set;
      ent_valid_o <= hit;
      ret_valid_o <= ~hit & ret_i;
      if (hit) begin
        kind_o <= win;
        lr_o   <= e_lr;
        spsr_o <= e_spsr;
        cpsr_o <= e_cpsr;
        pc_o   <= e_vec;
      end else if (ret_i) begin
        kind_o <= ret_kind_i;
        cpsr_o <= r_cpsr;
        pc_o   <= r_pc;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_req_i,
  input logic          dabt_i,
  input logic          fiq_i,
  input logic [DW-1:0] cpsr_i,
  input logic          ret_i,
  input logic [DW-1:0] ret_spsr_i,
  input logic          chain_q,
  input logic          ent_valid_o,
  input logic          ret_valid_o,
  input logic [2:0]    kind_o,
  input logic [DW-1:0] spsr_o,
  input logic [DW-1:0] cpsr_o,
  input logic [DW-1:0] pc_o
);
  assert_reset_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (ent_valid_o && kind_o == 3'd0 && pc_o == '0));

  assert_abort_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dabt_i && fiq_i && !cpsr_i[6] && !rst_req_i && !chain_q) |=> (ent_valid_o && kind_o == 3'd4));

  assert_fiq_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dabt_i && fiq_i && !cpsr_i[6] && !rst_req_i && !chain_q) ##1 !rst_req_i)
      |=> (ent_valid_o && kind_o == 3'd7 && pc_o[5:0] == 6'h1C));

  assert_spsr_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && !$past(chain_q)) |-> spsr_o == $past(cpsr_i));

  assert_fiq_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && kind_o == 3'd7) |-> cpsr_o[4:0] == 5'b10001);

  assert_t_clear_i_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> (!cpsr_o[5] && cpsr_o[7]));

  assert_f_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && (kind_o == 3'd7 || kind_o == 3'd0)) |-> cpsr_o[6]);

  assert_vec_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> pc_o[1:0] == 2'b00);

  assert_one_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ent_valid_o, ret_valid_o}));

  assert_ret_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> (cpsr_o == $past(ret_spsr_i) && $past(ret_i)));
endmodule

bind exc_seq exc_seq_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_i  (rst_req_i),
  .dabt_i     (dabt_i),
  .fiq_i      (fiq_i),
  .cpsr_i     (cpsr_i),
  .ret_i      (ret_i),
  .ret_spsr_i (ret_spsr_i),
  .chain_q    (chain_q),
  .ent_valid_o(ent_valid_o),
  .ret_valid_o(ret_valid_o),
  .kind_o     (kind_o),
  .spsr_o     (spsr_o),
  .cpsr_o     (cpsr_o),
  .pc_o       (pc_o)
);

// File: tb/tb_exc_seq.sv
`timescale 1ns/1ps
module tb_exc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 0, dabt = 0, fiq = 0, irq = 0, pabt = 0, und = 0, swi = 0, bkpt = 0;
  logic [31:0] pc = 0, cpsr = 0;
  logic        ret = 0;
  logic [2:0]  ret_kind = 0;
  logic [31:0] ret_lr = 0, ret_spsr = 0;
  logic        ent_valid, ret_valid;
  logic [2:0]  kind;
  logic [31:0] lr, spsr, cpsr_n, pc_n;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .dabt_i(dabt), .fiq_i(fiq),
    .irq_i(irq), .pabt_i(pabt), .und_i(und), .swi_i(swi), .bkpt_i(bkpt),
    .pc_i(pc), .cpsr_i(cpsr), .ret_i(ret), .ret_kind_i(ret_kind),
    .ret_lr_i(ret_lr), .ret_spsr_i(ret_spsr),
    .ent_valid_o(ent_valid), .ret_valid_o(ret_valid), .kind_o(kind),
    .lr_o(lr), .spsr_o(spsr), .cpsr_o(cpsr_n), .pc_o(pc_n));

  // behavioural reference
  bit          m_chain;
  bit          m_ev, m_rv;
  int          m_kind;
  logic [31:0] m_lr, m_spsr, m_cpsr, m_pc;

  function automatic int vec_of(int k);
    int t[8] = '{0, 4, 8, 12, 16, 12, 24, 28};
    return t[k];
  endfunction
  function automatic int mode_val(int k);
    int t[8] = '{19, 27, 19, 23, 23, 23, 18, 17};
    return t[k];
  endfunction
  function automatic int back_off(int k);
    int t[8] = '{0, 0, 0, 4, 8, 4, 4, 4};
    return t[k];
  endfunction
  function automatic int fwd_off(int k, bit th);
    if (k == 4) return 8;
    if ((k == 1 || k == 2) && th) return 2;
    return 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain = 0; m_ev = 0; m_rv = 0; m_kind = 0;
      m_lr = 0; m_spsr = 0; m_cpsr = 0; m_pc = 0;
    end else begin
      automatic int k = -1;
      automatic bit from_c = 0;
      automatic bit nxt_chain = 0;
      automatic logic [31:0] bpc, bst, c;
      if (rst_req) k = 0;
      else if (m_chain) begin k = 7; from_c = 1; end
      else if (dabt) k = 4;
      else if (fiq && !cpsr[6]) k = 7;
      else if (irq && !cpsr[7]) k = 6;
      else if (pabt) k = 3;
      else if (bkpt) k = 5;
      else if (und) k = 1;
      else if (swi) k = 2;
      nxt_chain = (k == 4) && fiq && !cpsr[6];
      if (k >= 0) begin
        bpc = from_c ? 32'h10 : pc;
        bst = from_c ? m_cpsr : cpsr;
        m_lr = (k == 0) ? 32'h0 : bpc + fwd_off(k, bst[5]);
        m_spsr = bst;
        c = bst;
        c[4:0] = mode_val(k);
        c[5] = 0;
        c[7] = 1;
        if (k == 0 || k == 7) c[6] = 1;
        m_cpsr = c;
        m_pc = vec_of(k);
        m_kind = k; m_ev = 1; m_rv = 0;
      end else if (ret) begin
        m_pc = ret_lr - back_off(ret_kind);
        m_cpsr = ret_spsr;
        m_kind = ret_kind; m_ev = 0; m_rv = 1;
      end else begin
        m_ev = 0; m_rv = 0;
      end
      m_chain = nxt_chain;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R1 ent_valid (model)", 32'(ent_valid), 32'(m_ev));
      chk("R10 ret_valid (model)", 32'(ret_valid), 32'(m_rv));
      chk("R1 kind (model)", 32'(kind), 32'(m_kind));
      chk("R4/R5 link (model)", lr, m_lr);
      chk("R6 spsr (model)", spsr, m_spsr);
      chk("R8 cpsr (model)", cpsr_n, m_cpsr);
      chk("R9 pc (model)", pc_n, m_pc);
    end
  end

  task automatic clear_in();
    rst_req = 0; dabt = 0; fiq = 0; irq = 0; pabt = 0; und = 0; swi = 0; bkpt = 0; ret = 0;
  endtask

  task automatic frame(string tag, int k, logic [31:0] elr, logic [31:0] esp,
                       logic [31:0] ecp, logic [31:0] epc);
    chk({tag, " valid"}, 32'(ent_valid), 1);
    chk({tag, " kind"}, 32'(kind), 32'(k));
    chk({tag, " link"}, lr, elr);
    chk({tag, " spsr"}, spsr, esp);
    chk({tag, " cpsr"}, cpsr_n, ecp);
    chk({tag, " vector"}, pc_n, epc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset ent_valid", 32'(ent_valid), 0);
    chk("R11 reset ret_valid", 32'(ret_valid), 0);
    chk("R11 reset pc", pc_n, 0);
    rst_n = 1;
    model_on = 1;

    // SWI, 32-bit state
    @(negedge clk); swi = 1; pc = 32'h100; cpsr = 32'hF000_0010;
    @(negedge clk); clear_in();
    frame("R4 R6 R7 R8 R9 swi", 2, 32'h104, 32'hF000_0010, 32'hF000_0093, 32'h08);
    // undefined, 16-bit state
    und = 1; pc = 32'h202; cpsr = 32'h30;
    @(negedge clk); clear_in();
    frame("R5 und thumb", 1, 32'h204, 32'h30, 32'h9B, 32'h04);
    // data abort, 16-bit state
    dabt = 1; pc = 32'h300; cpsr = 32'h30;
    @(negedge clk); clear_in();
    frame("R5 dabt thumb", 4, 32'h308, 32'h30, 32'h97, 32'h10);
    @(negedge clk);
    // breakpoint, 16-bit state
    bkpt = 1; pc = 32'h500; cpsr = 32'h30;
    @(negedge clk); clear_in();
    frame("R5 R9 bkpt thumb", 5, 32'h504, 32'h30, 32'h97, 32'h0C);
    // masked IRQ ignored
    irq = 1; cpsr = 32'h90;
    @(negedge clk); clear_in();
    chk("R1 masked irq no entry", 32'(ent_valid), 0);
    // IRQ beats prefetch abort
    irq = 1; pabt = 1; pc = 32'h600; cpsr = 32'h10;
    @(negedge clk); clear_in();
    frame("R1 irq over pabt", 6, 32'h604, 32'h10, 32'h92, 32'h18);
    // abort + FIQ together, IRQ in the chain cycle is dropped
    dabt = 1; fiq = 1; pc = 32'h400; cpsr = 32'h10;
    @(negedge clk); clear_in(); irq = 1;
    frame("R2 abort first", 4, 32'h408, 32'h10, 32'h97, 32'h10);
    @(negedge clk); clear_in();
    frame("R2 chained fiq", 7, 32'h14, 32'h97, 32'hD7 & 32'hFFFF_FFE0 | 32'h11, 32'h1C);
    @(negedge clk);
    chk("R2 irq dropped in chain cycle", 32'(ent_valid), 0);
    // return from chained FIQ resumes abort handler
    ret = 1; ret_kind = 3'd7; ret_lr = 32'h14; ret_spsr = 32'h97;
    @(negedge clk); clear_in();
    chk("R3 fiq return pc", pc_n, 32'h10);
    chk("R10 fiq return cpsr", cpsr_n, 32'h97);
    chk("R10 return valid", 32'(ret_valid), 1);
    // return from data abort
    ret = 1; ret_kind = 3'd4; ret_lr = 32'h408; ret_spsr = 32'h10;
    @(negedge clk); clear_in();
    chk("R10 dabt return pc", pc_n, 32'h400);
    // return with SWI present: return dropped
    ret = 1; ret_kind = 3'd6; ret_lr = 32'h900; swi = 1; pc = 32'h700; cpsr = 32'h10;
    @(negedge clk); clear_in();
    chk("R10 return dropped", 32'(ret_valid), 0);
    chk("R10 swi wins pc", pc_n, 32'h08);
    // abort with masked FIQ: no second entry
    dabt = 1; fiq = 1; pc = 32'h800; cpsr = 32'h50;
    @(negedge clk); clear_in();
    chk("R2 abort masked fiq", 32'(kind), 4);
    @(negedge clk);
    chk("R2 no chain when masked", 32'(ent_valid), 0);
    // hold while idle
    @(negedge clk);
    chk("R11 hold pc", pc_n, 32'h10);
    // reset request
    rst_req = 1; dabt = 1; pc = 32'hA00; cpsr = 32'h30;
    @(negedge clk); clear_in();
    frame("R1 R7 R9 reset", 0, 32'h0, 32'h30, 32'hD3, 32'h0);

    // random phase, compared against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      clear_in();
      rst_req = ($urandom_range(0, 99) == 0);
      dabt = ($urandom_range(0, 5) == 0);
      fiq  = ($urandom_range(0, 4) == 0);
      irq  = ($urandom_range(0, 3) == 0);
      pabt = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 5))
        0: und = 1;
        1: swi = 1;
        2: bkpt = 1;
        default: ;
      endcase
      pc   = $urandom & ~32'h1;
      cpsr = $urandom;
      ret  = $urandom_range(0, 1);
      ret_kind = 3'($urandom_range(0, 7));
      ret_lr = $urandom;
      ret_spsr = $urandom;
    end
    @(negedge clk); clear_in();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule